// File: doc/BRIEF.md
# Simulated Commutation Event Compare Unit

This block paces a sensorless motor-commutation sequence when no real back-EMF event is available. A 16-bit event timer counts on a clock-enable tick. Three compare registers, one per event type, are written by software and checked against that timer. A step of the sequence runs in a fixed order: commutation, then demagnetisation, then zero-crossing, and back to commutation. For each event type, an enable bit selects the source. When the bit is set, the compare register produces a simulated event. When it is clear, a pulse on the matching hardware-event input advances that step.

Only the compare for the current step of the sequence is armed. An armed compare fires once the timer has reached its value. Any value less than or equal to the timer counts, so a value written "in the past" fires at once and does not wait for the 16-bit counter to wrap. When a compare fires, the timer value at that instant is written back into the register. Software can then read the real event time and use it as the base for the next value. A commutation event clears the timer, so each step is timed from its own commutation.

Top module: `sim_event_cmp`

## Requirements
- R1: After synchronous reset the timer reads 0, all three compare registers read 0xFFFF, no event pulse is high, and the sequence waits for a commutation event.
- R2: The timer adds one on each clock edge with `tick_en` high and holds otherwise. `tmr_clr` clears it to 0, and the clear wins over a tick. The timer wraps from 0xFFFF to 0.
- R3: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_sel` on the next edge: 0 commutation, 1 demagnetisation, 2 zero-crossing. `rd_data` shows, with no delay, the register chosen by `rd_sel` (same codes), and code 3 shows the timer.
- R4: Events follow the order commutation, demagnetisation, zero-crossing, commutation. Only the compare of the current step is armed, and a compare of another step never fires.
- R5: An armed compare fires in any cycle in which its value is less than or equal to the timer, so a value already passed fires at once. `evt_pulse` (bit 0 commutation, bit 1 demagnetisation, bit 2 zero-crossing) is high for the single cycle after that edge.
- R6: When a compare fires, the register takes the timer value of that cycle.
- R7: A commutation event, simulated or hardware, clears the timer to 0.
- R8: If a write and a compare capture hit the same register in the same cycle, the capture wins.
- R9: With its `sim_en` bit low, an event's compare is not armed: it neither fires nor captures. Instead, a high `hw_evt` bit for the current step advances the sequence and pulses that event. A `hw_evt` bit is ignored while its `sim_en` bit is high or its step is not current.
- R10: At most one `evt_pulse` bit is high at a time, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer count enable |
| tmr_clr | input | 1 | Synchronous timer clear |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 2 | Register chosen for the write |
| wr_data | input | 16 | Write value |
| sim_en | input | 3 | Simulated-source enable per event type |
| hw_evt | input | 3 | Hardware-detected event pulses per event type |
| rd_sel | input | 2 | Readback select (3 = timer) |
| rd_data | output | 16 | Readback value |
| evt_pulse | output | 3 | One-cycle event pulses |

## Verification
The assertions check on every cycle that the pulses are one-hot and never last two cycles in a row, and that they come in commutation, demagnetisation, zero-crossing order. They also check that the timer either counts, holds or is cleared by a commutation. Two more cycle checks cover the capture of the timer value whenever a simulated event fires, and the silence of a disabled event that has no hardware pulse. Only the bench scenarios can show the following:
- the exact cycle at which a compare equal to the timer fires;
- an immediate fire after software writes a value already passed;
- the capture winning over a colliding write;
- a hardware pulse ignored while simulation is enabled;
- the wrap of the timer.

// File: rtl/sev_pkg.sv
`timescale 1ns/1ps
package sev_pkg;

    localparam int TMR_W_DEF = 16;
    localparam int EVT_N     = 3;

    // Event indices: also the write/read select codes and pulse bit positions
    localparam int EVT_COM = 0;
    localparam int EVT_DEM = 1;
    localparam int EVT_ZC  = 2;

    typedef enum logic [1:0] {
        PH_COM = 2'd0,
        PH_DEM = 2'd1,
        PH_ZC  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RD_COM = 2'd0,
        RD_DEM = 2'd1,
        RD_ZC  = 2'd2,
        RD_TMR = 2'd3
    } rdsel_e;

    typedef struct packed {
        phase_e               phase;
        logic [EVT_N-1:0]     step;
    } seq_state_t;

    function automatic phase_e next_phase(input phase_e cur);
        case (cur)
            PH_COM:  return PH_DEM;
            PH_DEM:  return PH_ZC;
            default: return PH_COM;
        endcase
    endfunction

endpackage

// File: rtl/sev_timer.sv
`timescale 1ns/1ps
module sev_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] val
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val <= '0;
        end else if (tick) begin
            val <= val + W'(1);
        end
    end

endmodule

// File: rtl/sev_cmp_slot.sv
`timescale 1ns/1ps
module sev_cmp_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         armed,
    input  logic [W-1:0] timer,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic         fire,
    output logic [W-1:0] val
);

    // A value at or behind the timer fires at once; no wait for a wrap.
    assign fire = armed && (val <= timer);

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '1;
        end else if (fire) begin
            val <= timer;          // capture has priority over a write
        end else if (wr_hit) begin
            val <= wr_data;
        end
    end

endmodule

// File: rtl/sev_sequencer.sv
`timescale 1ns/1ps
module sev_sequencer
    import sev_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] fire,
    input  logic [EVT_N-1:0] hw,
    input  logic [EVT_N-1:0] sim_en,
    output seq_state_t       state,
    output logic [EVT_N-1:0] evt_q
);

    phase_e           phase_q;
    logic [EVT_N-1:0] step;

    always_comb begin
        for (int i = 0; i < EVT_N; i++) begin
            step[i] = (phase_q == phase_e'(2'(i))) && (sim_en[i] ? fire[i] : hw[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COM;
            evt_q   <= '0;
        end else begin
            evt_q <= step;
            if (|step) begin
                phase_q <= next_phase(phase_q);
            end
        end
    end

    assign state.phase = phase_q;
    assign state.step  = step;

endmodule

// File: rtl/sim_event_cmp.sv
`timescale 1ns/1ps
module sim_event_cmp
    import sev_pkg::*;
#(
    parameter int TMR_W = TMR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             tmr_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [TMR_W-1:0] wr_data,
    input  logic [2:0]       sim_en,
    input  logic [2:0]       hw_evt,
    input  logic [1:0]       rd_sel,
    output logic [TMR_W-1:0] rd_data,
    output logic [2:0]       evt_pulse
);

    logic [TMR_W-1:0]                tmr_val;
    logic [EVT_N-1:0][TMR_W-1:0]     cmp_val;
    logic [EVT_N-1:0]                armed;
    logic [EVT_N-1:0]                wr_hit;
    logic [EVT_N-1:0]                fire;
    seq_state_t                      seq;

    sev_timer #(.W(TMR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_en),
        .clr  (tmr_clr || seq.step[EVT_COM]),
        .val  (tmr_val)
    );

    for (genvar i = 0; i < EVT_N; i++) begin : g_slot
        assign armed[i]  = (seq.phase == phase_e'(2'(i))) && sim_en[i];
        assign wr_hit[i] = wr_en && (wr_sel == 2'(i));

        sev_cmp_slot #(.W(TMR_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .armed   (armed[i]),
            .timer   (tmr_val),
            .wr_hit  (wr_hit[i]),
            .wr_data (wr_data),
            .fire    (fire[i]),
            .val     (cmp_val[i])
        );
    end

    sev_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .hw     (hw_evt),
        .sim_en (sim_en),
        .state  (seq),
        .evt_q  (evt_pulse)
    );

    always_comb begin
        case (rdsel_e'(rd_sel))
            RD_COM:  rd_data = cmp_val[EVT_COM];
            RD_DEM:  rd_data = cmp_val[EVT_DEM];
            RD_ZC:   rd_data = cmp_val[EVT_ZC];
            default: rd_data = tmr_val;
        endcase
    end

endmodule

// File: rtl/sim_event_cmp_chk.sv
`timescale 1ns/1ps
module sim_event_cmp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic         tmr_clr,
    input logic [2:0]   sim_en,
    input logic [2:0]   hw_evt,
    input logic [2:0]   evt_pulse,
    input logic [W-1:0] tmr_val,
    input logic [W-1:0] cmp_com,
    input logic [W-1:0] cmp_dem,
    input logic [W-1:0] cmp_zc
);

    logic [2:0] expect_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            expect_nxt <= 3'b001;
        end else if (|evt_pulse) begin
            expect_nxt <= {expect_nxt[1:0], expect_nxt[2]};
        end
    end

    assert_evt_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_pulse));

    assert_com_single_R10: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[0] |=> !evt_pulse[0]);

    assert_evt_order_R4: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse) |-> (evt_pulse == expect_nxt));

    assert_com_clears_R7: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[0] |-> (tmr_val == '0));

    assert_tmr_count_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !tmr_clr) |=> (evt_pulse[0] || tmr_val == $past(tmr_val) + W'(1)));

    assert_tmr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !tmr_clr) |=> (evt_pulse[0] || $stable(tmr_val)));

    assert_capture_com_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[0] && $past(sim_en[0])) |-> (cmp_com == $past(tmr_val)));

    assert_capture_dem_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[1] && $past(sim_en[1])) |-> (cmp_dem == $past(tmr_val)));

    assert_capture_zc_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[2] && $past(sim_en[2])) |-> (cmp_zc == $past(tmr_val)));

    assert_dem_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (!sim_en[1] && !hw_evt[1]) |=> !evt_pulse[1]);

    assert_zc_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (!sim_en[2] && !hw_evt[2]) |=> !evt_pulse[2]);

endmodule

bind sim_event_cmp sim_event_cmp_chk #(.W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .tmr_clr   (tmr_clr),
    .sim_en    (sim_en),
    .hw_evt    (hw_evt),
    .evt_pulse (evt_pulse),
    .tmr_val   (tmr_val),
    .cmp_com   (cmp_val[0]),
    .cmp_dem   (cmp_val[1]),
    .cmp_zc    (cmp_val[2])
);

// File: tb/sim_event_cmp_test.sv
`timescale 1ns/1ps
module sim_event_cmp_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        tmr_clr;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [2:0]  sim_en;
    logic [2:0]  hw_evt;
    logic [1:0]  rd_sel;
    logic [15:0] rd_data;
    logic [2:0]  evt_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    sim_event_cmp uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .tmr_clr   (tmr_clr),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sim_en    (sim_en),
        .hw_evt    (hw_evt),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .evt_pulse (evt_pulse)
    );

    typedef struct packed {
        logic        tick;
        logic        wr;
        logic [1:0]  wsel;
        logic [15:0] wdat;
        logic [2:0]  en;     // {zc, dem, com}
        logic [2:0]  hw;     // {zc, dem, com}
        logic [1:0]  rsel;
        logic [2:0]  xevt;
        logic [15:0] xrd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,2'd0,16'd5,3'b000,3'b000,2'd0,3'b000,16'd5,4'd3}, // R3 write com
        '{1'b0,1'b1,2'd1,16'd3,3'b111,3'b000,2'd1,3'b000,16'd3,4'd3}, // R3 write dem
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd1,4'd2}, // R2 tick
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd2,4'd2},
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd3,4'd2},
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd4,4'd2},
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd5,4'd5}, // R5 not yet reached
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b001,16'd0,4'd7}, // R5 R7 com fires, timer cleared
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b000,2'd0,3'b000,16'd5,4'd10},// R10 single pulse, R6 com=5
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd1,4'd4}, // R4 dem armed
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd2,4'd4},
        '{1'b1,1'b0,2'd0,16'd0,3'b111,3'b000,2'd3,3'b000,16'd3,4'd4},
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b000,2'd1,3'b010,16'd3,4'd4}, // R4 dem after com
        '{1'b0,1'b1,2'd2,16'd1,3'b111,3'b000,2'd2,3'b000,16'd1,4'd3}, // R3 zc written in the past
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b000,2'd2,3'b100,16'd3,4'd6}, // R5 R6 immediate + capture
        '{1'b0,1'b1,2'd0,16'd2,3'b111,3'b000,2'd0,3'b000,16'd2,4'd3}, // R3 com := 2 (<timer)
        '{1'b0,1'b1,2'd0,16'd9,3'b111,3'b000,2'd0,3'b001,16'd3,4'd8}, // R8 capture beats write
        '{1'b1,1'b0,2'd0,16'd0,3'b101,3'b000,2'd3,3'b000,16'd1,4'd9}, // R9 dem disabled
        '{1'b1,1'b0,2'd0,16'd0,3'b101,3'b000,2'd3,3'b000,16'd2,4'd9},
        '{1'b1,1'b0,2'd0,16'd0,3'b101,3'b000,2'd3,3'b000,16'd3,4'd9},
        '{1'b1,1'b0,2'd0,16'd0,3'b101,3'b000,2'd3,3'b000,16'd4,4'd9}, // R9 passed match, no fire
        '{1'b0,1'b0,2'd0,16'd0,3'b101,3'b000,2'd1,3'b000,16'd3,4'd9}, // R9 no capture
        '{1'b0,1'b0,2'd0,16'd0,3'b101,3'b010,2'd3,3'b010,16'd4,4'd9}, // R9 hw dem advances
        '{1'b0,1'b0,2'd0,16'd0,3'b011,3'b001,2'd3,3'b000,16'd4,4'd4}, // R4 hw com wrong step
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b000,2'd2,3'b100,16'd4,4'd6}, // R6 zc captures 4
        '{1'b0,1'b0,2'd0,16'd0,3'b110,3'b000,2'd3,3'b000,16'd4,4'd9}, // R9 com disabled
        '{1'b0,1'b0,2'd0,16'd0,3'b110,3'b001,2'd0,3'b001,16'd3,4'd9}, // R9 hw com, no capture
        '{1'b0,1'b0,2'd0,16'd0,3'b111,3'b010,2'd3,3'b000,16'd0,4'd9}  // R9 hw ignored when enabled
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tick_en = 1'b0; tmr_clr = 1'b0; wr_en = 1'b0; wr_sel = 2'd0;
        wr_data = 16'd0; sim_en = 3'b000; hw_evt = 3'b000;
    endtask

    task automatic read_check(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        rd_sel = sel;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle();
        rd_sel = 2'd0;
        rst = 1'b1;
        edge_step();
        edge_step();
        rst = 1'b0;

        // R1 reset state
        check("R1 evt", 16'(evt_pulse), 16'd0);
        read_check("R1 com", 2'd0, 16'hFFFF);
        read_check("R1 dem", 2'd1, 16'hFFFF);
        read_check("R1 zc",  2'd2, 16'hFFFF);
        read_check("R1 timer", 2'd3, 16'd0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            tick_en = VECS[k].tick;
            wr_en   = VECS[k].wr;
            wr_sel  = VECS[k].wsel;
            wr_data = VECS[k].wdat;
            sim_en  = VECS[k].en;
            hw_evt  = VECS[k].hw;
            rd_sel  = VECS[k].rsel;
            tmr_clr = 1'b0;
            edge_step();
            check($sformatf("R%0d vec%0d evt", VECS[k].req, k), 16'(evt_pulse), 16'(VECS[k].xevt));
            check($sformatf("R%0d vec%0d rd", VECS[k].req, k), rd_data, VECS[k].xrd);
        end

        // R2 clear beats tick
        idle();
        tick_en = 1'b1;
        repeat (3) edge_step();
        read_check("R2 count", 2'd3, 16'd3);
        tmr_clr = 1'b1;
        edge_step();
        read_check("R2 clear", 2'd3, 16'd0);
        tmr_clr = 1'b0;

        // R2 wrap
        repeat (65535) @(posedge clk);
        @(negedge clk);
        read_check("R2 top", 2'd3, 16'hFFFF);
        edge_step();
        read_check("R2 wrap", 2'd3, 16'd0);
        tick_en = 1'b0;

        // R1 reset in mid-run
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd7;
        edge_step();
        wr_en = 1'b0;
        read_check("R3 dem=7", 2'd1, 16'd7);
        rst = 1'b1;
        edge_step();
        rst = 1'b0;
        read_check("R1 dem after reset", 2'd1, 16'hFFFF);
        check("R1 evt after reset", 16'(evt_pulse), 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule